// File: doc/BRIEF.md
# Cascaded Two-Group DMA Channel Priority Arbiter

This block chooses which of seven DMA channels is served next. The channels are 0–3 and 5–7, and they form two cascaded groups. The lower group (channels 0–3) is treated as one entry inside the upper group, where it takes the place of channel 4. The upper group therefore has four entries: the lower group, then 5, 6 and 7. Each group has its own mode input. In fixed mode a group keeps its natural order. In rotating mode the entry that was served last drops to the bottom of its group.

A channel requests service when its hardware request line or its software request bit is high; the two sources are treated the same. The result is registered and given as a one-hot grant vector. While `xfer_busy` is high the grant does not change. A `svc_done` pulse tells the block that the granted channel has finished its service. In every group that is rotating, this pulse moves the priority pointer.

Top module: `dma_cascade_arb`

## Requirements
- R1: A channel's effective request is the OR of `hw_req[n]` and `sw_req[n]`; a request from either source alone wins the same way.
- R2: With both groups in fixed mode, the priority from highest to lowest is 0, 1, 2, 3, 5, 6, 7. Bit n of `grant` is channel n.
- R3: `grant` has at most one bit set. It is all zeros one cycle after a non-busy cycle in which no channel requested.
- R4: Bit 4 of `grant` is never set. Requests on bit 4 of `hw_req` and `sw_req` have no effect.
- R5: When `xfer_busy` is low, `grant` shows the arbitration of the inputs from the previous clock edge. When `xfer_busy` is high, `grant` keeps its value.
- R6: With `lo_rotate` high, a `svc_done` for lower channel c makes c the lowest in the lower group, and (c+1) mod 4 becomes the highest.
- R7: With `hi_rotate` high, a `svc_done` for upper entry e makes e the lowest entry of the upper group. The entries are numbered: 0 for the lower group, 1 for channel 5, 2 for channel 6, 3 for channel 7.
- R8: A `svc_done` for any of channels 0–3 counts as service of upper entry 0.
- R9: A `svc_done` leaves the pointer of a fixed-mode group unchanged. A `svc_done` while `grant` is zero changes no pointer. An arbitration in the same cycle as a `svc_done` already uses the updated pointers.
- R10: After reset, `grant` is zero and both pointers make channel 0 and the lower-group entry the highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | 8 | Hardware request lines, bit n is channel n |
| sw_req | input | 8 | Software request bits, bit n is channel n |
| lo_rotate | input | 1 | 1 = lower group (0–3) rotates, 0 = fixed |
| hi_rotate | input | 1 | 1 = upper group rotates, 0 = fixed |
| xfer_busy | input | 1 | Holds the current grant |
| svc_done | input | 1 | Single-cycle pulse: the granted channel finished service |
| grant | output | 8 | One-hot grant, bit n is channel n |

## Verification
The fixed order is checked by taking requests away one at a time, starting from all requests high, so each step shows the next channel in the order. Requests from only the software bits, from a mix of both sources, and from only the cascade bit show whether the two sources are treated the same and whether bit 4 is ignored. Runs of `svc_done` with all four lower channels requesting, and then with the upper entries requesting, show the two rotations separately. A mixed run shows that service of a lower channel also moves the upper pointer. A long random run, compared cycle by cycle with a model that walks a priority list, covers mixed modes, busy holds and done pulses on an empty grant.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int GRP_N   = 4;
  localparam int GRP_W   = $clog2(GRP_N);
  localparam int CH_N    = 2 * GRP_N;
  localparam int SLOT_CH = GRP_N;

  // one-hot (at most) group vector to its index
  function automatic logic [GRP_W-1:0] oh_to_idx(input logic [GRP_N-1:0] v);
    logic [GRP_W-1:0] r;
    r = '0;
    for (int i = 0; i < GRP_N; i++)
      if (v[i]) r = r | GRP_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/dma_rot_group.sv
module dma_rot_group #(
  parameter int N = 4,
  localparam int PW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          rotate,
  input  logic          upd,
  input  logic [PW-1:0] upd_idx,
  output logic [N-1:0]  pick
);
  logic [PW-1:0] top_q, top_nxt, top_eff;
  logic          ptr_move;

  // highest-priority entry first: walk from lowest up, later hits win
  function automatic logic [N-1:0] pick_from(input logic [N-1:0] r,
                                             input logic [PW-1:0] top);
    logic [N-1:0]  p;
    logic [PW-1:0] idx;
    p = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = top + PW'(k);
      if (r[idx]) p = N'(1) << idx;
    end
    return p;
  endfunction

  assign ptr_move = upd && rotate;
  assign top_nxt  = ptr_move ? upd_idx + PW'(1) : top_q;
  assign top_eff  = rotate ? top_nxt : '0;
  assign pick     = pick_from(req, top_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) top_q <= '0;
    else        top_q <= top_nxt;
  end

  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_move |=> $stable(top_q));
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_move |=> top_q == $past(upd_idx) + PW'(1));
  a_r3_group_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));
endmodule

// File: rtl/dma_grant_hold.sv
module dma_grant_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic [W-1:0] next_grant,
  output logic [W-1:0] grant
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    grant <= '0;
    else if (!busy) grant <= next_grant;
  end

  a_r5_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(grant));
  a_r5_follow_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> grant == $past(next_grant));
endmodule

// File: rtl/dma_cascade_arb.sv
module dma_cascade_arb
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] hw_req,
  input  logic [7:0] sw_req,
  input  logic       lo_rotate,
  input  logic       hi_rotate,
  input  logic       xfer_busy,
  input  logic       svc_done,
  output logic [7:0] grant
);
  logic [CH_N-1:0]  req_eff;
  logic [GRP_N-1:0] lo_req, hi_req, lo_pick, hi_pick;
  logic [CH_N-1:0]  grant_nxt, grant_q;
  logic             lo_served, any_served;
  logic [GRP_W-1:0] lo_idx, hi_idx;

  // cascade slot carries no request of its own
  assign req_eff = (hw_req | sw_req) & ~(CH_N'(1) << SLOT_CH);
  assign lo_req  = req_eff[GRP_N-1:0];
  assign hi_req  = {req_eff[CH_N-1:SLOT_CH+1], |lo_req};

  assign lo_served  = svc_done && (|grant_q[GRP_N-1:0]);
  assign any_served = svc_done && (|grant_q);
  assign lo_idx     = oh_to_idx(grant_q[GRP_N-1:0]);
  assign hi_idx     = (|grant_q[GRP_N-1:0]) ? '0 : oh_to_idx(grant_q[CH_N-1:GRP_N]);

  dma_rot_group #(.N(GRP_N)) u_lo (
    .clk(clk), .rst_n(rst_n), .req(lo_req), .rotate(lo_rotate),
    .upd(lo_served), .upd_idx(lo_idx), .pick(lo_pick));

  dma_rot_group #(.N(GRP_N)) u_hi (
    .clk(clk), .rst_n(rst_n), .req(hi_req), .rotate(hi_rotate),
    .upd(any_served), .upd_idx(hi_idx), .pick(hi_pick));

  assign grant_nxt = {hi_pick[GRP_N-1:1], 1'b0,
                      hi_pick[0] ? lo_pick : {GRP_N{1'b0}}};

  dma_grant_hold #(.W(CH_N)) u_hold (
    .clk(clk), .rst_n(rst_n), .busy(xfer_busy),
    .next_grant(grant_nxt), .grant(grant_q));

  assign grant = grant_q;

  a_r4_no_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_q[SLOT_CH]);
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_busy && req_eff == '0) |=> grant_q == '0);
  a_r1_grant_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy |=> (grant_q == '0) || ((grant_q & $past(req_eff)) != '0));
  a_r2_fixed_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_busy && !lo_rotate && !hi_rotate && req_eff[0]) |=> grant_q[0]);
endmodule

// File: tb/dma_cascade_arb_test.sv
module dma_cascade_arb_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] hw_req = '0, sw_req = '0;
  logic       lo_rotate = 1'b0, hi_rotate = 1'b0, xfer_busy = 1'b0, svc_done = 1'b0;
  logic [7:0] grant;

  int checks = 0, errors = 0;
  string tag = "R10";
  int lt = 0, ht = 0;
  logic [7:0] mg = '0;
  int wd = 0;

  always #4 clk = ~clk;

  dma_cascade_arb uut (.*);

  // list-walk reference: build the priority order and take the first requester
  function automatic logic [7:0] ref_pick(logic [7:0] r, int l, int h, logic lr, logic hr);
    int e, c;
    for (int k = 0; k < 4; k++) begin
      e = hr ? (h + k) % 4 : k;
      if (e == 0) begin
        for (int j = 0; j < 4; j++) begin
          c = lr ? (l + j) % 4 : j;
          if (r[c]) return 8'(1) << c;
        end
      end else if (r[e + 4]) return 8'(1) << (e + 4);
    end
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lt = 0; ht = 0; mg = '0;
    end else begin
      if (svc_done && mg != 0) begin
        int ch;
        ch = 0;
        for (int i = 0; i < 8; i++) if (mg[i]) ch = i;
        if (lo_rotate && ch < 4) lt = (ch + 1) % 4;
        if (hi_rotate) ht = ((ch < 4 ? 0 : ch - 4) + 1) % 4;
      end
      if (!xfer_busy)
        mg = ref_pick((hw_req | sw_req) & 8'hEF, lt, ht, lo_rotate, hi_rotate);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", wd, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (grant !== mg) begin
      errors++;
      $display("FAIL %s: grant=%b expected=%b", tag, grant, mg);
    end
  endtask

  task automatic expect_g(logic [7:0] exp);
    checks++;
    if (grant !== exp) begin
      errors++;
      $display("FAIL %s: grant=%b expected=%b", tag, grant, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    tag = "R10"; expect_g(8'h00);
    rst_n = 1'b1;
    // R2: fixed order, peel requests off
    tag = "R2";
    hw_req = 8'hEF; cyc(); expect_g(8'h01);
    hw_req = 8'hEE; cyc(); expect_g(8'h02);
    hw_req = 8'hE8; cyc(); expect_g(8'h08);
    hw_req = 8'hE0; cyc(); expect_g(8'h20);
    hw_req = 8'hC0; cyc(); expect_g(8'h40);
    hw_req = 8'h80; cyc(); expect_g(8'h80);
    // R1: software bits alone and mixed
    tag = "R1";
    hw_req = 8'h00; sw_req = 8'h40; cyc(); expect_g(8'h40);
    hw_req = 8'h80; sw_req = 8'h04; cyc(); expect_g(8'h04);
    // R4: cascade bit ignored
    tag = "R4";
    hw_req = 8'h10; sw_req = 8'h10; cyc(); expect_g(8'h00);
    // R3: empty request
    tag = "R3";
    hw_req = 8'h00; sw_req = 8'h00; cyc(); expect_g(8'h00);
    // R5: hold while busy
    tag = "R5";
    hw_req = 8'h20; cyc(); expect_g(8'h20);
    xfer_busy = 1'b1; hw_req = 8'h21; cyc(); expect_g(8'h20);
    cyc(); expect_g(8'h20);
    xfer_busy = 1'b0; cyc(); expect_g(8'h01);
    // R6: lower rotation
    tag = "R6";
    lo_rotate = 1'b1; hw_req = 8'h0F; cyc(); expect_g(8'h01);
    svc_done = 1'b1;
    cyc(); expect_g(8'h02);
    cyc(); expect_g(8'h04);
    cyc(); expect_g(8'h08);
    cyc(); expect_g(8'h01);
    svc_done = 1'b0;
    // R7: upper rotation
    tag = "R7";
    lo_rotate = 1'b0; hi_rotate = 1'b1; hw_req = 8'hE1; cyc(); expect_g(8'h01);
    svc_done = 1'b1;
    cyc(); expect_g(8'h20);
    cyc(); expect_g(8'h40);
    cyc(); expect_g(8'h80);
    cyc(); expect_g(8'h01);
    svc_done = 1'b0;
    // R8: lower service moves the upper pointer
    tag = "R8";
    lo_rotate = 1'b1; hw_req = 8'h23; cyc(); expect_g(8'h01);
    svc_done = 1'b1;
    cyc(); expect_g(8'h20);
    cyc(); expect_g(8'h02);
    cyc(); expect_g(8'h20);
    svc_done = 1'b0;
    // R10: reset restores pointers
    tag = "R10";
    rst_n = 1'b0; @(negedge clk); expect_g(8'h00);
    rst_n = 1'b1; hw_req = 8'hEF; cyc(); expect_g(8'h01);
    // R9: done in fixed mode and on empty grant leaves pointers
    tag = "R9";
    lo_rotate = 1'b0; hi_rotate = 1'b0; hw_req = 8'h0F; svc_done = 1'b1;
    cyc(); cyc(); expect_g(8'h01);
    svc_done = 1'b0; lo_rotate = 1'b1; hi_rotate = 1'b1; cyc(); expect_g(8'h01);
    hw_req = 8'h00; cyc(); expect_g(8'h00);
    svc_done = 1'b1; cyc();
    svc_done = 1'b0; hw_req = 8'h0F; cyc(); expect_g(8'h01);
    // random run against the model
    tag = "R7";
    for (int n = 0; n < 3000; n++) begin
      hw_req    = 8'($urandom);
      sw_req    = 8'($urandom) & 8'($urandom);
      lo_rotate = (n % 700) > 150;
      hi_rotate = (n % 500) > 120;
      xfer_busy = ($urandom % 4) == 0;
      svc_done  = ($urandom % 3) == 0;
      cyc();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule